// File: doc/BRIEF.md
# Queue Interrupt Source Selector

This block turns per-queue status flags into two interrupt lines for a bank of 64 hardware queues. The queues form a lower group of 32 and an upper group of 32. Each lower queue reports four flags: empty, nearly-empty, nearly-full and full. Software picks one of eight trigger conditions for each lower queue: one of the four flags being set, or one of them being clear. Each upper queue reports only a nearly-empty flag and a full flag. Its trigger is always nearly-empty. The full flag is only mirrored into a readable register.

When a queue's condition becomes true, the block latches an event in a sticky status bit. Software clears that bit by writing 1 to it. Each group has an enable register. The AND of status and enable, ORed across the group, drives that group's interrupt output through a register.

A simple register port carries all configuration and status traffic. It has a write strobe, a read strobe, a 4-bit word address and 32-bit data. It is a control interface, so it has no valid/ready handshake. A write completes in the cycle it is strobed. Read data appears on the cycle after the read strobe.

Bit 3 of select word 0 is a global control bit, driven out on `glob_ctl`. The per-queue select write never touches it.

Top module: `qirq_srcsel`

## Requirements
- R1: After reset:
  - All select words read 0, both enable words read 0 and `glob_ctl` is 0.
  - Both sticky status words read 0xFFFFFFFF.
  - The upper nearly-empty mirror reads 0xFFFFFFFF and the upper full mirror reads 0.
  - `irq_lo` and `irq_hi` are 0.
- R2: A lower queue's condition is its flag number `code[1:0]` compared against 1 when `code[2]`=0, and against 0 when `code[2]`=1.
  - Codes 0–7 are: empty, nearly-empty, nearly-full, full, not-empty, not-nearly-empty, not-nearly-full, not-full.
  - Flag nibble q of `lo_flags` (bits 4q+3..4q) carries empty at bit 0, nearly-empty at bit 1, nearly-full at bit 2 and full at bit 3.
- R3: A sticky status bit sets on a false-to-true transition of its queue's condition.
  - Flags are sampled at one clock edge, and the status bit is 1 after the next edge.
  - A bit never sets without such a transition.
- R4: Writing the lower status word (address 7) or the upper status word (address 8) clears every bit written as 1. Bits written as 0 are left unchanged.
- R5: An upper queue's condition is its nearly-empty flag (`hi_ne`). The `hi_full` input never sets a status bit. `hi_full` is readable, registered, at address 10. `hi_ne` is readable, registered, at address 9.
- R6: Select-word layout and the word write:
  - Lower queue q has its 3-bit code in select word q/8 (addresses 0–3), at bits 4*(q%8)+2..4*(q%8).
  - A word write stores every code field.
  - Bit 3 of every slot reads 0, except slot 0 of word 0.
- R7: `glob_ctl` comes from bit 3 of select word 0:
  - A word write to address 0 sets or clears it.
  - The per-queue select write (address 4: queue in `wdata[4:0]`, code in `wdata[10:8]`) changes only the addressed queue's three code bits and never that control bit.
- R8: The interrupt outputs:
  - `irq_lo` and `irq_hi` are the registered OR of status AND enable over their group. The enables are at address 5 (lower) and address 6 (upper).
  - An output rises one edge after its status bit sets, so two edges after the flag is sampled.
- R9: `reg_rdata` holds the addressed word on the cycle after `reg_re`. Unmapped addresses (11–15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| lo_flags | input | 128 | Four status flags per lower queue |
| hi_ne | input | 32 | Nearly-empty flag per upper queue |
| hi_full | input | 32 | Full flag per upper queue |
| irq_lo | output | 1 | Lower-group interrupt |
| irq_hi | output | 1 | Upper-group interrupt |
| glob_ctl | output | 1 | Global control bit from select word 0 |

## Verification
The bench builds the block with its default parameters: 32 queues per group on a 32-bit register word. With these values all four lower select words, every slot position and both interrupt groups are reachable. This includes queue 0's shared slot and the last slot of the last word. The vector walk takes each condition from false to true through all eight codes, spread across those slots. Directed tests cover the control bit, clear-on-write-1, the mirror of the full flag, and the exact cycle at which the interrupt rises.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

  // Trigger condition codes; bit 2 inverts, bits 1:0 index the flag nibble.
  typedef enum logic [2:0] {
    SRC_EMPTY       = 3'd0,
    SRC_NEMPTY      = 3'd1,
    SRC_NFULL       = 3'd2,
    SRC_FULL        = 3'd3,
    SRC_NOT_EMPTY   = 3'd4,
    SRC_NOT_NEMPTY  = 3'd5,
    SRC_NOT_NFULL   = 3'd6,
    SRC_NOT_FULL    = 3'd7
  } src_sel_e;

  localparam int unsigned FLAG_W   = 4;   // flags per lower queue
  localparam int unsigned CODE_W   = 3;   // select code width
  localparam int unsigned SLOT_W   = 4;   // slot width in a select word
  localparam int unsigned QSEL_LSB = 8;   // code field of the per-queue write
  localparam int unsigned ADDR_W   = 4;

  // Reset value of a lower flag nibble: empty and nearly-empty set.
  localparam logic [FLAG_W-1:0] FLAG_RST = 4'b0011;

  localparam logic [ADDR_W-1:0] A_SEL0   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SELQ   = 4'd4;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 4'd6;
  localparam logic [ADDR_W-1:0] A_ST_LO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ST_HI  = 4'd8;
  localparam logic [ADDR_W-1:0] A_HI_NE  = 4'd9;
  localparam logic [ADDR_W-1:0] A_HI_FUL = 4'd10;

endpackage

// File: rtl/qirq_match.sv
module qirq_match
  import qirq_pkg::*;
#(
  parameter int unsigned NQ = 32
) (
  input  logic [NQ*FLAG_W-1:0]          flags_i,
  input  logic [NQ-1:0][CODE_W-1:0]     code_i,
  output logic [NQ-1:0]                 cond_o
);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    src_sel_e              sel;
    logic [FLAG_W-1:0]     nib;
    logic                  picked;
    assign sel    = src_sel_e'(code_i[q]);
    assign nib    = flags_i[q*FLAG_W +: FLAG_W];
    assign picked = nib[sel[1:0]];
    // Positive codes want the flag set, inverted codes want it clear.
    assign cond_o[q] = (picked == ~sel[2]);
  end

endmodule

// File: rtl/qirq_cfg.sv
module qirq_cfg
  import qirq_pkg::*;
#(
  parameter int unsigned NQ = 32,
  parameter int unsigned NH = 32,
  parameter int unsigned DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [NQ-1:0][CODE_W-1:0]   code_o,
  output logic                        ctl_o,
  output logic [NQ-1:0]               en_lo_o,
  output logic [NH-1:0]               en_hi_o,
  output logic [NQ*SLOT_W/DW-1:0][DW-1:0] sel_word_o
);

  localparam int unsigned SLOTS = DW / SLOT_W;
  localparam int unsigned NREG  = NQ / SLOTS;
  localparam int unsigned QW    = $clog2(NQ);

  logic [NQ-1:0][CODE_W-1:0] code_q;
  logic                      ctl_q;
  logic                      q_we;
  logic [QW-1:0]             q_idx;
  logic [CODE_W-1:0]         q_code;

  assign q_we   = we_i && (addr_i == A_SELQ);
  assign q_idx  = wdata_i[QW-1:0];
  assign q_code = wdata_i[QSEL_LSB +: CODE_W];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic word_we;
    assign word_we = we_i && (addr_i == ADDR_W'(A_SEL0 + r));
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int unsigned Q = r * SLOTS + s;
      always_ff @(posedge clk) begin
        if (!rst_n)                       code_q[Q] <= '0;
        else if (word_we)                 code_q[Q] <= wdata_i[s*SLOT_W +: CODE_W];
        else if (q_we && q_idx == QW'(Q)) code_q[Q] <= q_code;
      end
      if (r == 0 && s == 0) begin : g_ctl
        assign sel_word_o[r][s*SLOT_W +: SLOT_W] = {ctl_q, code_q[Q]};
      end else begin : g_rsv
        assign sel_word_o[r][s*SLOT_W +: SLOT_W] = {1'b0, code_q[Q]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= 1'b0;
      en_lo_o <= '0;
      en_hi_o <= '0;
    end else if (we_i) begin
      if (addr_i == A_SEL0)  ctl_q   <= wdata_i[CODE_W];
      if (addr_i == A_EN_LO) en_lo_o <= wdata_i[NQ-1:0];
      if (addr_i == A_EN_HI) en_hi_o <= wdata_i[NH-1:0];
    end
  end

  assign code_o = code_q;
  assign ctl_o  = ctl_q;

  AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    q_we |=> (ctl_o == $past(ctl_o))); // R7

endmodule

// File: rtl/qirq_sticky.sv
module qirq_sticky #(
  parameter int unsigned N = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cond_i,
  input  logic          clr_we_i,
  input  logic [N-1:0]  clr_i,
  input  logic [N-1:0]  en_i,
  output logic [N-1:0]  st_o,
  output logic          irq_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] st_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_m;

  assign rise  = cond_i & ~prev_q;
  assign clr_m = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '1;
      st_q   <= '1;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= cond_i;
      st_q   <= (st_q & ~clr_m) | rise;   // a new event beats a clear
      irq_o  <= |(st_q & en_i);
    end
  end

  assign st_o = st_q;

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((st_q & $past(rise)) == $past(rise))); // R3
  AST_ONLY_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & ~$past(st_q) & ~$past(rise)) == '0)); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((st_q & $past(clr_i & ~rise)) == '0)); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o); // R8

endmodule

// File: rtl/qirq_srcsel.sv
module qirq_srcsel
  import qirq_pkg::*;
#(
  parameter int unsigned NQ_LO = 32,
  parameter int unsigned NQ_HI = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic                     reg_re,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic [NQ_LO*FLAG_W-1:0]  lo_flags,
  input  logic [NQ_HI-1:0]         hi_ne,
  input  logic [NQ_HI-1:0]         hi_full,
  output logic                     irq_lo,
  output logic                     irq_hi,
  output logic                     glob_ctl
);

  localparam int unsigned NREG = NQ_LO * SLOT_W / DW;

  logic [NQ_LO*FLAG_W-1:0]      lo_flags_q;
  logic [NQ_HI-1:0]             hi_ne_q;
  logic [NQ_HI-1:0]             hi_full_q;
  logic [NQ_LO-1:0][CODE_W-1:0] code;
  logic [NQ_LO-1:0]             en_lo;
  logic [NQ_HI-1:0]             en_hi;
  logic [NREG-1:0][DW-1:0]      sel_word;
  logic [NQ_LO-1:0]             cond_lo;
  logic [NQ_LO-1:0]             st_lo;
  logic [NQ_HI-1:0]             st_hi;
  logic [DW-1:0]                rd_d;

  // Flag sampling stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_flags_q <= {NQ_LO{FLAG_RST}};
      hi_ne_q    <= '1;
      hi_full_q  <= '0;
    end else begin
      lo_flags_q <= lo_flags;
      hi_ne_q    <= hi_ne;
      hi_full_q  <= hi_full;
    end
  end

  qirq_cfg #(.NQ(NQ_LO), .NH(NQ_HI), .DW(DW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .code_o     (code),
    .ctl_o      (glob_ctl),
    .en_lo_o    (en_lo),
    .en_hi_o    (en_hi),
    .sel_word_o (sel_word)
  );

  qirq_match #(.NQ(NQ_LO)) u_match (
    .flags_i (lo_flags_q),
    .code_i  (code),
    .cond_o  (cond_lo)
  );

  qirq_sticky #(.N(NQ_LO)) u_st_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (cond_lo),
    .clr_we_i (reg_we && reg_addr == A_ST_LO),
    .clr_i    (reg_wdata[NQ_LO-1:0]),
    .en_i     (en_lo),
    .st_o     (st_lo),
    .irq_o    (irq_lo)
  );

  qirq_sticky #(.N(NQ_HI)) u_st_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (hi_ne_q),
    .clr_we_i (reg_we && reg_addr == A_ST_HI),
    .clr_i    (reg_wdata[NQ_HI-1:0]),
    .en_i     (en_hi),
    .st_o     (st_hi),
    .irq_o    (irq_hi)
  );

  // Read mux
  always_comb begin
    rd_d = '0;
    for (int r = 0; r < NREG; r++) begin
      if (reg_addr == ADDR_W'(A_SEL0 + r)) rd_d = sel_word[r];
    end
    case (reg_addr)
      A_EN_LO:  rd_d = DW'(en_lo);
      A_EN_HI:  rd_d = DW'(en_hi);
      A_ST_LO:  rd_d = DW'(st_lo);
      A_ST_HI:  rd_d = DW'(st_hi);
      A_HI_NE:  rd_d = DW'(hi_ne_q);
      A_HI_FUL: rd_d = DW'(hi_full_q);
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_d;
  end

  AST_FULL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(hi_ne_q) && !(reg_we && reg_addr == A_ST_HI)) |=> $stable(st_hi)); // R5

endmodule

// File: tb/qirq_srcsel_tb.sv
module qirq_srcsel_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we, reg_re;
  logic [3:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [127:0] lo_flags;
  logic [31:0]  hi_ne, hi_full;
  logic         irq_lo, irq_hi, glob_ctl;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  qirq_srcsel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lo_flags(lo_flags), .hi_ne(hi_ne), .hi_full(hi_full),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .glob_ctl(glob_ctl)
  );

  // {queue[4:0], code[2:0], nibble[3:0], expected condition}
  localparam logic [12:0] VEC [12] = '{
    {5'd0,  3'd0, 4'b0001, 1'b1},
    {5'd1,  3'd1, 4'b0001, 1'b0},
    {5'd7,  3'd2, 4'b0100, 1'b1},
    {5'd8,  3'd3, 4'b1000, 1'b1},
    {5'd9,  3'd4, 4'b0000, 1'b1},
    {5'd15, 3'd5, 4'b0010, 1'b0},
    {5'd16, 3'd6, 4'b1011, 1'b1},
    {5'd23, 3'd7, 4'b0111, 1'b1},
    {5'd24, 3'd7, 4'b1000, 1'b0},
    {5'd31, 3'd0, 4'b1110, 1'b0},
    {5'd30, 3'd2, 4'b1011, 1'b0},
    {5'd5,  3'd5, 4'b1101, 1'b1}
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    lo_flags = '0; hi_ne = '1; hi_full = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      rd(4'(r), d); check("R1 select word", d, 32'h0);
    end
    rd(4'd5, d);  check("R1 lower enable", d, 32'h0);
    rd(4'd6, d);  check("R1 upper enable", d, 32'h0);
    rd(4'd7, d);  check("R1 lower status", d, 32'hFFFF_FFFF);
    rd(4'd8, d);  check("R1 upper status", d, 32'hFFFF_FFFF);
    rd(4'd9, d);  check("R1 upper ne mirror", d, 32'hFFFF_FFFF);
    rd(4'd10, d); check("R1 upper full mirror", d, 32'h0);
    check("R1 irq_lo", 32'(irq_lo), 32'h0);
    check("R1 irq_hi", 32'(irq_hi), 32'h0);
    check("R1 glob_ctl", 32'(glob_ctl), 32'h0);

    // R4 write 0 leaves bits, write 1 clears
    wr(4'd8, 32'h0000_FFFF);
    rd(4'd8, d); check("R4 partial clear", d, 32'hFFFF_0000);

    // R2/R3 vector walk
    foreach (VEC[i]) begin
      logic [4:0] q;   logic [2:0] code;
      logic [3:0] nib; logic exp;
      {q, code, nib, exp} = VEC[i];
      lo_flags[q*4 +: 4] = ~nib;
      wr(4'd4, {21'd0, code, 3'd0, q});
      wait_cyc(3);
      wr(4'd7, 32'hFFFF_FFFF);
      wait_cyc(2);
      lo_flags[q*4 +: 4] = nib;
      wait_cyc(3);
      rd(4'd7, d);
      check($sformatf("R2 R3 vector %0d queue %0d", i, q), 32'(d[q]), 32'(exp));
    end

    // R6 layout and reserved bits, R7 control bit
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); check("R6 word write codes only", d, 32'h7777_7777);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R6 R7 word 0 with control", d, 32'h7777_777F);
    check("R7 glob_ctl set", 32'(glob_ctl), 32'h1);
    wr(4'd4, {21'd0, 3'd2, 3'd0, 5'd0});
    rd(4'd0, d); check("R7 queue 0 write keeps bit 3", d, 32'h7777_777A);
    check("R7 glob_ctl held", 32'(glob_ctl), 32'h1);
    wr(4'd4, {21'd0, 3'd0, 3'd0, 5'd12});
    rd(4'd1, d); check("R6 queue 12 slot", d, 32'h7770_7777);
    wr(4'd0, 32'h0);
    check("R7 glob_ctl cleared", 32'(glob_ctl), 32'h0);

    // R5 upper group: full has no effect, ne rising sets
    hi_ne[3] = 1'b0;
    wait_cyc(3);
    wr(4'd8, 32'hFFFF_FFFF);
    hi_full = 32'hFFFF_FFFF;
    wait_cyc(3);
    rd(4'd8, d);  check("R5 full no event", d, 32'h0);
    rd(4'd10, d); check("R5 full mirror", d, 32'hFFFF_FFFF);
    hi_ne[3] = 1'b1;
    wait_cyc(3);
    rd(4'd8, d);  check("R5 ne rise sets", d, 32'h0000_0008);

    // R8 interrupt enable and clear
    wr(4'd6, 32'h0000_0008);
    wait_cyc(1);
    check("R8 irq_hi on", 32'(irq_hi), 32'h1);
    check("R8 irq_lo masked", 32'(irq_lo), 32'h0);
    wr(4'd8, 32'h0000_0008);
    wait_cyc(1);
    check("R8 irq_hi off after clear", 32'(irq_hi), 32'h0);

    // R3/R8 exact timing of upper event to interrupt
    wr(4'd6, 32'h0000_0020);
    hi_ne[5] = 1'b0;
    wait_cyc(3);
    wr(4'd8, 32'hFFFF_FFFF);
    wait_cyc(1);
    hi_ne[5] = 1'b1;
    @(negedge clk);
    check("R3 no event after sampling edge", 32'(irq_hi), 32'h0);
    @(negedge clk);
    check("R8 irq not before status edge", 32'(irq_hi), 32'h0);
    @(negedge clk);
    check("R8 irq rises one edge after status", 32'(irq_hi), 32'h1);

    // R9 unmapped read
    rd(4'd13, d); check("R9 unmapped reads 0", d, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule